// File: doc/BRIEF.md
# Indexed Configuration Register Window

This block gives a host a byte-wide view of a configuration register file through a pair of adjacent I/O ports. The host first writes a register number to the index port. It then reads or writes the chosen register through the data port, which sits one address above. A strap input picks which of two fixed base addresses the pair answers at. This lets two parts share a board without colliding.

Some registers are global: a read-only chip identifier, a read-only revision number, and a device-select register. Every other implemented register is banked. The device-select value decides which device's bank the host sees. Each bank holds an enable bit and a 16-bit I/O base address. All banks drive their values straight out of the block, so that address decode elsewhere in the chip can locate and switch on each function.

Reads are combinational: the data appears on the read bus during the same cycle as the read strobe. Writes are captured at the rising clock edge on which the write strobe is high.

Top module: `sio_cfg_window`

## Requirements
- R1: The port pair answers at 0x2E (index) and 0x2F (data) while `strap_alt` is 0, and at 0x4E and 0x4F while it is 1. A write to any other address changes nothing. A read from any other address, and any cycle without `io_rd`, returns 0x00.
- R2: A read of the index port returns the last value written to it.
- R3: Index 0x20 reads as 0xE9 through the data port. Writes to it have no effect.
- R4: Index 0x27 reads as the `REVISION` parameter (default 0x09). Writes to it have no effect.
- R5: Index 0x07 is the device-select register. It is a full byte, readable and writable.
- R6: Index 0x30 bit 0 is the enable bit of the selected device and drives `dev_active[n]` for device n. Bits 7:1 read as 0.
- R7: Index 0x60 is the high byte and index 0x61 the low byte of the selected device's base address. Device n's base address appears on `dev_base[16n+15:16n]`.
- R8: A data-port write to 0x30, 0x60 or 0x61 changes only the bank whose number equals the device-select value. When that value is NUM_DEV (default 16) or above, such writes change nothing and reads of these indices return 0x00.
- R9: Indices other than 0x07, 0x20, 0x27, 0x30, 0x60 and 0x61 read as 0x00. Writes to them change no output and no readable register.
- R10: After reset, the index register and the device-select register are 0x00, every `dev_active` bit is 0, and every base address is 0x0000.
- R11: A data-port write reaches the outputs at the clock edge on which `io_wr` is sampled high. The outputs do not change before that edge and show the new value right after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_alt | input | 1 | Base select: 0 gives 0x2E/0x2F, 1 gives 0x4E/0x4F |
| io_addr | input | ADDR_W | Host I/O address |
| io_wr | input | 1 | Host write strobe |
| io_rd | input | 1 | Host read strobe |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Host read data, combinational |
| dev_active | output | NUM_DEV | Enable bit of each device |
| dev_base | output | 16*NUM_DEV | Base address of each device, device n in bits 16n+15:16n |

## Verification
The hardest case to reach is a write that lands in one bank while every other bank must stay untouched. To hit it, the host has to change the device-select value, move the index to a banked register and then write data, all in that order. Out-of-range select values and strap changes in the middle of the sequence make it harder still. The random stimulus reaches this state by giving high weight to the banked and select indices and by mixing in select values above the device count. After every write, the bench compares all enable bits and all base addresses against its own model. Directed sequences cover the write timing at the clock edge, the read-only identifiers and the alternate base address.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
   localparam logic [7:0] IX_DEVSEL  = 8'h07;
   localparam logic [7:0] IX_CHIPID  = 8'h20;
   localparam logic [7:0] IX_REV     = 8'h27;
   localparam logic [7:0] IX_ENABLE  = 8'h30;
   localparam logic [7:0] IX_BASE_HI = 8'h60;
   localparam logic [7:0] IX_BASE_LO = 8'h61;
   localparam logic [7:0] CHIP_ID    = 8'hE9;

   typedef enum logic [1:0] {
      PORT_NONE  = 2'd0,
      PORT_INDEX = 2'd1,
      PORT_DATA  = 2'd2
   } port_sel_e;

   typedef struct packed {
      logic        act;
      logic [15:0] base;
   } dev_cfg_t;
endpackage

// File: rtl/sio_cfg_decode.sv
module sio_cfg_decode
   import sio_cfg_pkg::*;
#(
   parameter int          ADDR_W       = 16,
   parameter logic [15:0] PRIMARY_BASE = 16'h002E,
   parameter logic [15:0] ALT_BASE     = 16'h004E,
   parameter bit          STRAP_EN     = 1'b1
) (
   input  logic              strap_alt,
   input  logic [ADDR_W-1:0] io_addr,
   output port_sel_e         sel
);
   localparam logic [ADDR_W-1:0] PRI_IX = PRIMARY_BASE[ADDR_W-1:0];
   localparam logic [ADDR_W-1:0] ALT_IX = ALT_BASE[ADDR_W-1:0];

   logic [ADDR_W-1:0] base;

   generate
      if (STRAP_EN) begin : g_strap
         assign base = strap_alt ? ALT_IX : PRI_IX;
      end else begin : g_fixed
         logic unused_strap;
         assign unused_strap = strap_alt;
         assign base = PRI_IX;
      end
   endgenerate

   always_comb begin
      if (io_addr == base)
         sel = PORT_INDEX;
      else if (io_addr == base + ADDR_W'(1))
         sel = PORT_DATA;
      else
         sel = PORT_NONE;
   end
endmodule

// File: rtl/sio_cfg_globals.sv
module sio_cfg_globals
   import sio_cfg_pkg::*;
#(
   parameter logic [7:0] REVISION = 8'h09
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       idx_wr,
   input  logic       data_wr,
   input  logic [7:0] wdata,
   output logic [7:0] idx_q,
   output logic [7:0] ldn_q,
   output logic [7:0] glb_rdata
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q <= 8'h00;
         ldn_q <= 8'h00;
      end else begin
         if (idx_wr)
            idx_q <= wdata;
         if (data_wr && idx_q == IX_DEVSEL)
            ldn_q <= wdata;
      end
   end

   always_comb begin
      unique case (idx_q)
         IX_DEVSEL: glb_rdata = ldn_q;
         IX_CHIPID: glb_rdata = CHIP_ID;
         IX_REV:    glb_rdata = REVISION;
         default:   glb_rdata = 8'h00;
      endcase
   end
endmodule

// File: rtl/sio_cfg_bank.sv
module sio_cfg_bank
   import sio_cfg_pkg::*;
#(
   parameter int DEV_NUM = 0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        data_wr,
   input  logic [7:0]  idx,
   input  logic [7:0]  ldn,
   input  logic [7:0]  wdata,
   output dev_cfg_t    cfg,
   output logic [7:0]  rdata
);
   localparam logic [7:0] MY_LDN = 8'(DEV_NUM);

   logic picked;
   assign picked = (ldn == MY_LDN);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg <= '0;
      end else if (data_wr && picked) begin
         case (idx)
            IX_ENABLE:  cfg.act        <= wdata[0];
            IX_BASE_HI: cfg.base[15:8] <= wdata;
            IX_BASE_LO: cfg.base[7:0]  <= wdata;
            default: ;
         endcase
      end
   end

   always_comb begin
      rdata = 8'h00;
      if (picked) begin
         case (idx)
            IX_ENABLE:  rdata = {7'b0, cfg.act};
            IX_BASE_HI: rdata = cfg.base[15:8];
            IX_BASE_LO: rdata = cfg.base[7:0];
            default:    rdata = 8'h00;
         endcase
      end
   end
endmodule

// File: rtl/sio_cfg_window.sv
module sio_cfg_window
   import sio_cfg_pkg::*;
#(
   parameter int          ADDR_W       = 16,
   parameter int          NUM_DEV      = 16,
   parameter logic [7:0]  REVISION     = 8'h09,
   parameter logic [15:0] PRIMARY_BASE = 16'h002E,
   parameter logic [15:0] ALT_BASE     = 16'h004E,
   parameter bit          STRAP_EN     = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    strap_alt,
   input  logic [ADDR_W-1:0]       io_addr,
   input  logic                    io_wr,
   input  logic                    io_rd,
   input  logic [7:0]              io_wdata,
   output logic [7:0]              io_rdata,
   output logic [NUM_DEV-1:0]      dev_active,
   output logic [16*NUM_DEV-1:0]   dev_base
);
   localparam int BASE_W = 16;

   generate
      if (ADDR_W < 8 || ADDR_W > 16) begin : g_bad_addr
         $error("ADDR_W must lie in 8..16");
      end
      if (NUM_DEV < 1 || NUM_DEV > 256) begin : g_bad_dev
         $error("NUM_DEV must lie in 1..256");
      end
      if (PRIMARY_BASE == ALT_BASE) begin : g_bad_base
         $error("the two base addresses must differ");
      end
   endgenerate

   port_sel_e  sel;
   logic       idx_wr, data_wr;
   logic [7:0] idx_q, ldn_q, glb_rdata, bank_or;
   logic [7:0] bank_rd [NUM_DEV];

   sio_cfg_decode #(
      .ADDR_W(ADDR_W), .PRIMARY_BASE(PRIMARY_BASE),
      .ALT_BASE(ALT_BASE), .STRAP_EN(STRAP_EN)
   ) u_dec (
      .strap_alt(strap_alt), .io_addr(io_addr), .sel(sel)
   );

   assign idx_wr  = io_wr && (sel == PORT_INDEX);
   assign data_wr = io_wr && (sel == PORT_DATA);

   sio_cfg_globals #(.REVISION(REVISION)) u_glb (
      .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .data_wr(data_wr),
      .wdata(io_wdata), .idx_q(idx_q), .ldn_q(ldn_q), .glb_rdata(glb_rdata)
   );

   generate
      for (genvar n = 0; n < NUM_DEV; n++) begin : g_bank
         dev_cfg_t cfg_n;
         sio_cfg_bank #(.DEV_NUM(n)) u_bank (
            .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .idx(idx_q),
            .ldn(ldn_q), .wdata(io_wdata), .cfg(cfg_n), .rdata(bank_rd[n])
         );
         assign dev_active[n]                 = cfg_n.act;
         assign dev_base[n*BASE_W +: BASE_W]  = cfg_n.base;
      end
   endgenerate

   always_comb begin
      bank_or = 8'h00;
      for (int n = 0; n < NUM_DEV; n++)
         bank_or = bank_or | bank_rd[n];
   end

   always_comb begin
      io_rdata = 8'h00;
      if (io_rd) begin
         case (sel)
            PORT_INDEX: io_rdata = idx_q;
            PORT_DATA:  io_rdata = glb_rdata | bank_or;
            default:    io_rdata = 8'h00;
         endcase
      end
   end
endmodule

// File: rtl/sio_cfg_window_chk.sv
module sio_cfg_window_chk #(
   parameter int          ADDR_W       = 16,
   parameter int          NUM_DEV      = 16,
   parameter logic [15:0] PRIMARY_BASE = 16'h002E,
   parameter logic [15:0] ALT_BASE     = 16'h004E
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  strap_alt,
   input logic [ADDR_W-1:0]     io_addr,
   input logic                  io_wr,
   input logic                  io_rd,
   input logic [7:0]            io_wdata,
   input logic [7:0]            io_rdata,
   input logic [NUM_DEV-1:0]    dev_active,
   input logic [16*NUM_DEV-1:0] dev_base,
   input logic [7:0]            idx_q,
   input logic [7:0]            ldn_q
);
   logic [ADDR_W-1:0] ix_port, dt_port;
   logic on_ix, on_dt;
   assign ix_port = strap_alt ? ALT_BASE[ADDR_W-1:0] : PRIMARY_BASE[ADDR_W-1:0];
   assign dt_port = ix_port + ADDR_W'(1);
   assign on_ix   = (io_addr == ix_port);
   assign on_dt   = (io_addr == dt_port);

   p_outside_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!io_rd || (!on_ix && !on_dt)) |-> io_rdata == 8'h00);

   p_index_echo_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && on_ix) |=> idx_q == $past(io_wdata));

   p_chip_id_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd && on_dt && idx_q == 8'h20) |-> io_rdata == 8'hE9);

   p_devsel_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && on_dt && idx_q == 8'h07) |=> ldn_q == $past(io_wdata));

   generate
      for (genvar k = 0; k < NUM_DEV; k++) begin : g_dev
         p_enable_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (io_wr && on_dt && idx_q == 8'h30 && ldn_q == 8'(k))
            |=> dev_active[k] == $past(io_wdata[0]));

         p_other_bank_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !(io_wr && on_dt && ldn_q == 8'(k))
            |=> ($stable(dev_active[k]) && $stable(dev_base[k*16 +: 16])));
      end
   endgenerate
endmodule

bind sio_cfg_window sio_cfg_window_chk #(
   .ADDR_W(ADDR_W), .NUM_DEV(NUM_DEV),
   .PRIMARY_BASE(PRIMARY_BASE), .ALT_BASE(ALT_BASE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .strap_alt(strap_alt), .io_addr(io_addr),
   .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
   .dev_active(dev_active), .dev_base(dev_base), .idx_q(idx_q), .ldn_q(ldn_q)
);

// File: tb/sim_sio_cfg_window.sv
`timescale 1ns/1ps
module sim_sio_cfg_window;
   localparam int         AW   = 16;
   localparam int         ND   = 16;
   localparam logic [7:0] REV  = 8'h09;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           strap_alt = 1'b0;
   logic [AW-1:0]  io_addr = '0;
   logic           io_wr = 1'b0;
   logic           io_rd = 1'b0;
   logic [7:0]     io_wdata = 8'h00;
   logic [7:0]     io_rdata;
   logic [ND-1:0]  dev_active;
   logic [16*ND-1:0] dev_base;

   int n_chk = 0;
   int n_bad = 0;

   logic        m_act  [ND];
   logic [15:0] m_base [ND];
   logic [7:0]  m_idx, m_ldn;

   always #2.5 clk = ~clk;

   sio_cfg_window #(.ADDR_W(AW), .NUM_DEV(ND), .REVISION(REV)) u0 (
      .clk(clk), .rst_n(rst_n), .strap_alt(strap_alt), .io_addr(io_addr),
      .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
      .dev_active(dev_active), .dev_base(dev_base)
   );

   function automatic logic [AW-1:0] ix_addr();
      return strap_alt ? AW'(16'h004E) : AW'(16'h002E);
   endfunction

   function automatic logic [7:0] exp_reg(input logic [7:0] ix);
      logic in_rng;
      in_rng = (m_ldn < 8'(ND));
      case (ix)
         8'h07: return m_ldn;
         8'h20: return 8'hE9;
         8'h27: return REV;
         8'h30: return in_rng ? {7'b0, m_act[m_ldn[3:0]]} : 8'h00;
         8'h60: return in_rng ? m_base[m_ldn[3:0]][15:8] : 8'h00;
         8'h61: return in_rng ? m_base[m_ldn[3:0]][7:0] : 8'h00;
         default: return 8'h00;
      endcase
   endfunction

   function automatic logic [7:0] exp_read(input logic [AW-1:0] a);
      if (a == ix_addr()) return m_idx;
      if (a == ix_addr() + AW'(1)) return exp_reg(m_idx);
      return 8'h00;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic model_write(input logic [AW-1:0] a, input logic [7:0] d);
      if (a == ix_addr()) m_idx = d;
      else if (a == ix_addr() + AW'(1)) begin
         if (m_idx == 8'h07) m_ldn = d;
         else if (m_ldn < 8'(ND)) begin
            if (m_idx == 8'h30) m_act[m_ldn[3:0]] = d[0];
            if (m_idx == 8'h60) m_base[m_ldn[3:0]][15:8] = d;
            if (m_idx == 8'h61) m_base[m_ldn[3:0]][7:0] = d;
         end
      end
   endtask

   task automatic check_outputs(input string req);
      logic [ND-1:0] ea;
      logic [16*ND-1:0] eb;
      for (int k = 0; k < ND; k++) begin
         ea[k] = m_act[k];
         eb[k*16 +: 16] = m_base[k];
      end
      check({req, " enables"}, 32'(dev_active), 32'(ea));
      n_chk++;
      if (dev_base !== eb) begin
         n_bad++;
         $display("FAIL %s bases: got %h expected %h", req, dev_base, eb);
      end
   endtask

   task automatic bus_write(input logic [AW-1:0] a, input logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_wdata = d; io_wr = 1'b1;
      @(negedge clk);
      io_wr = 1'b0;
      model_write(a, d);
   endtask

   task automatic bus_read(input logic [AW-1:0] a, input string req);
      @(negedge clk);
      io_addr = a; io_rd = 1'b1;
      #1;
      check(req, 32'(io_rdata), 32'(exp_read(a)));
      io_rd = 1'b0;
   endtask

   task automatic set_reg(input logic [7:0] ix, input logic [7:0] d);
      bus_write(ix_addr(), ix);
      bus_write(ix_addr() + AW'(1), d);
   endtask

   task automatic read_reg(input logic [7:0] ix, input string req);
      bus_write(ix_addr(), ix);
      bus_read(ix_addr() + AW'(1), req);
   endtask

   initial begin
      #(5.0 * 200000);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      m_idx = 8'h00; m_ldn = 8'h00;
      for (int k = 0; k < ND; k++) begin m_act[k] = 1'b0; m_base[k] = 16'h0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R10 reset state
      @(negedge clk);
      check_outputs("R10");
      bus_read(16'h002E, "R10 index");
      bus_read(16'h002F, "R10 data at index 0");

      // R3 / R4 identifiers, writes ignored
      read_reg(8'h20, "R3 id");
      set_reg(8'h20, 8'h55);
      bus_read(16'h002F, "R3 id after write");
      read_reg(8'h27, "R4 rev");
      set_reg(8'h27, 8'hA5);
      bus_read(16'h002F, "R4 rev after write");

      // R5 device select, R2 index echo
      set_reg(8'h07, 8'h0E);
      read_reg(8'h07, "R5 devsel");
      bus_read(16'h002E, "R2 index echo");

      // R6 / R7 on device 14
      set_reg(8'h30, 8'hFF);
      bus_read(16'h002F, "R6 enable reads bit0 only");
      check_outputs("R6");
      set_reg(8'h60, 8'h12);
      set_reg(8'h61, 8'h34);
      check_outputs("R7");
      check("R7 dev14 base", 32'(dev_base[14*16 +: 16]), 32'h1234);

      // R11: new value only after the strobe edge
      bus_write(16'h002E, 8'h61);
      @(negedge clk);
      io_addr = 16'h002F; io_wdata = 8'hC3; io_wr = 1'b1;
      #1 check("R11 before edge", 32'(dev_base[14*16 +: 16]), 32'h1234);
      @(negedge clk);
      io_wr = 1'b0;
      model_write(16'h002F, 8'hC3);
      check("R11 after edge", 32'(dev_base[14*16 +: 16]), 32'h12C3);

      // R8 banking
      set_reg(8'h07, 8'h03);
      read_reg(8'h30, "R8 other bank enable");
      set_reg(8'h60, 8'hBE);
      check_outputs("R8 one bank written");
      set_reg(8'h07, 8'h20);
      set_reg(8'h30, 8'h01);
      set_reg(8'h61, 8'h77);
      check_outputs("R8 out-of-range select");
      read_reg(8'h61, "R8 out-of-range read");

      // R9 unimplemented index
      set_reg(8'h07, 8'h0E);
      set_reg(8'h31, 8'hFF);
      bus_read(16'h002F, "R9 unimplemented read");
      check_outputs("R9");

      // R1 alternate base
      strap_alt = 1'b1;
      bus_write(16'h002E, 8'h27);
      bus_read(16'h004E, "R1 old base write ignored");
      bus_read(16'h002F, "R1 old data port silent");
      read_reg(8'h27, "R1 alt base");
      bus_write(16'h1234, 8'h99);
      bus_read(16'h004E, "R1 stray write ignored");

      // random mix
      for (int i = 0; i < 600; i++) begin
         logic [7:0] pick, d;
         logic [AW-1:0] a;
         logic [7:0] ixs [8];
         ixs = '{8'h07, 8'h07, 8'h20, 8'h27, 8'h30, 8'h60, 8'h61, 8'h00};
         if ($urandom_range(0, 40) == 0) strap_alt = ~strap_alt;
         pick = 8'($urandom_range(0, 9));
         case ($urandom_range(0, 9))
            0, 1, 2, 3: a = ix_addr();
            4, 5, 6, 7, 8: a = ix_addr() + AW'(1);
            default: a = AW'($urandom);
         endcase
         if (a == ix_addr())
            d = (pick < 8) ? ixs[pick[2:0]] : 8'($urandom);
         else if (m_idx == 8'h07)
            d = 8'($urandom_range(0, 19));
         else
            d = 8'($urandom);
         if ($urandom_range(0, 2) == 0) bus_read(a, "R1 R2 R8 random read");
         else begin
            bus_write(a, d);
            check_outputs("R6 R7 R8 random");
         end
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule